// File: doc/BRIEF.md
# Strobe-Triggered Burst Sequencer

This block converts one strobe pulse into the full timed sequence of radio control enables for a transmit or a receive burst. Software loads the burst mode, the slot count and one parameter set per slot (modulation mode, power level, shutdown tail) ahead of time. The configuration is captured on the strobe edge, and nothing has to be written while the burst runs. A transmit burst warms up the synthesizer and then, for every slot in turn, ramps the power amplifier up, modulates, holds the modulator for that slot's shutdown tail and ramps down. A receive burst runs a DC-adapt phase and then streams data until a second strobe or a receive-end command arrives.

All phase changes fall on a quarter-symbol grid. A divider produces one tick every `TICK_DIV` clocks (24 at 26 MHz, so 96 clocks per symbol), and the divider restarts on the accepted strobe. An abort command ends any burst. A low-battery input ends a running transmit burst and refuses new transmit bursts until it returns high.

Top module: `burst_seq`

## Requirements
- R1: After reset all enables, `busy_o`, `slot_o`, `mode_o` and `power_o` are low.
- R2: Every phase boundary falls exactly `TICK_DIV`·N clocks after the edge that samples the accepted strobe. With the defaults, ramp-up begins 192 clocks after that edge and modulation begins 96 clocks later.
- R3: A transmit burst holds `synth_en_o` high throughout. It runs warm-up for `WARM_Q` ticks, ramp-up for `RAMP_Q` ticks, modulation for 4·`SLOT_SYM` ticks, a shutdown tail of the slot's delay in ticks with `mod_en_o` still high, and ramp-down for `RAMP_Q` ticks. It then returns to standby.
- R4: In a multi-slot burst the ramp-up/modulation/tail/ramp-down group repeats back to back once per slot, and each slot uses its own parameter set. Slot i occupies `cfg_slot_i[i*SLOT_W +: SLOT_W]`, with bit 0 = modulation mode, the next `PWR_W` bits = power level and the top `SD_W` bits = shutdown delay. During a transmit burst, `slot_o`, `mode_o` and `power_o` show the active slot's values.
- R5: A slot count of 0 runs one slot. A count above `SLOTS_MAX` (6) runs six slots.
- R6: Configuration is sampled only on the accepted strobe edge. Changes made during the burst have no effect on it.
- R7: A receive burst holds `rx_en_o` and `synth_en_o` high. `rx_data_o` is low for `DCA_Q` ticks of DC-adapt and then high. A strobe or `rx_end_i` during streaming ends the burst, and all outputs are low on the next cycle.
- R8: A strobe that arrives while busy is ignored, except a strobe during receive streaming. A strobe during DC-adapt leaves the burst unchanged.
- R9: With `batt_ok_i` low, a running transmit burst ends on the next cycle and a transmit strobe is refused. A receive strobe is still accepted.
- R10: `abort_i` ends any burst on the next cycle. A strobe in the same cycle as `abort_i` is ignored.
- R11: At most one of `ramp_up_o`, `ramp_dn_o`, `mod_en_o` and `rx_en_o` is high at any time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock (26 MHz nominal) |
| rst_n | input | 1 | Asynchronous active-low reset |
| strobe_i | input | 1 | Burst strobe, one-cycle pulse |
| rx_end_i | input | 1 | Receive-end command pulse |
| abort_i | input | 1 | Abort command pulse |
| batt_ok_i | input | 1 | Battery good; low blocks transmit |
| cfg_tx_i | input | 1 | Burst type: 1 transmit, 0 receive |
| cfg_slots_i | input | 3 | Transmit slot count |
| cfg_slot_i | input | SLOTS_MAX*SLOT_W (54) | Per-slot parameter sets |
| synth_en_o | output | 1 | Synthesizer enable |
| ramp_up_o | output | 1 | PA ramp-up phase |
| ramp_dn_o | output | 1 | PA ramp-down phase |
| mod_en_o | output | 1 | Modulator enable |
| rx_en_o | output | 1 | Receiver enable |
| rx_data_o | output | 1 | Receive data streaming phase |
| busy_o | output | 1 | Burst in progress |
| slot_o | output | 3 | Active transmit slot index |
| mode_o | output | 1 | Active slot modulation mode |
| power_o | output | PWR_W (5) | Active slot power level |

## Verification
Every phase output changes on the cycle after clock edge 24·N, where edge 0 is the one that samples the strobe. Abort, low battery, receive-end and a closing strobe each clear the outputs one cycle after the edge that samples them. The bench numbers each cycle from the strobe-sample edge and samples on falling edges. It computes each boundary from the slot parameters and checks the cycle before and the cycle at every boundary, so an output that moves one cycle early or late is caught. Inputs that cut a burst short are raised on a falling edge at a known index, and the bench expects the idle outputs at the next index.

// File: rtl/burst_seq.sv
module burst_seq #(
  parameter int TICK_DIV  = 24,
  parameter int WARM_Q    = 8,
  parameter int RAMP_Q    = 4,
  parameter int DCA_Q     = 6,
  parameter int SLOT_SYM  = 8,
  parameter int SLOTS_MAX = 6,
  parameter int PWR_W     = 5,
  parameter int SD_W      = 3
) (
  input  logic                                     clk,
  input  logic                                     rst_n,
  input  logic                                     strobe_i,
  input  logic                                     rx_end_i,
  input  logic                                     abort_i,
  input  logic                                     batt_ok_i,
  input  logic                                     cfg_tx_i,
  input  logic [$clog2(SLOTS_MAX+1)-1:0]           cfg_slots_i,
  input  logic [SLOTS_MAX*(1+PWR_W+SD_W)-1:0]      cfg_slot_i,
  output logic                                     synth_en_o,
  output logic                                     ramp_up_o,
  output logic                                     ramp_dn_o,
  output logic                                     mod_en_o,
  output logic                                     rx_en_o,
  output logic                                     rx_data_o,
  output logic                                     busy_o,
  output logic [$clog2(SLOTS_MAX+1)-1:0]           slot_o,
  output logic                                     mode_o,
  output logic [PWR_W-1:0]                         power_o
);
  function automatic int maxi(int a, int b);
    return (a > b) ? a : b;
  endfunction

  localparam int SLOT_W = 1 + PWR_W + SD_W;
  localparam int SLW    = $clog2(SLOTS_MAX + 1);
  localparam int MOD_Q  = 4 * SLOT_SYM;
  localparam int PH_MAX = maxi(maxi(WARM_Q, RAMP_Q), maxi(maxi(DCA_Q, MOD_Q), (1 << SD_W) - 1));
  localparam int PW     = $clog2(PH_MAX + 1);
  localparam int QW     = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;

  typedef enum logic [2:0] {S_IDLE, S_WARM, S_RUP, S_MOD, S_TAIL, S_RDN, S_RXDC, S_RXSTR} st_t;

  st_t                        st, st_nx;
  logic [QW-1:0]              qcnt;
  logic [PW-1:0]              pcnt, len;
  logic [SLW-1:0]             slot_q, nsl_q, nsl_in, slot_nx;
  logic [SLOTS_MAX*SLOT_W-1:0] cfg_q;
  logic [SLOT_W-1:0]          cur;
  logic [SD_W-1:0]            cur_sd;
  logic                       tick, last, tx_st, start, kill;

  assign cur     = cfg_q[slot_q*SLOT_W +: SLOT_W];
  assign cur_sd  = cur[SLOT_W-1 -: SD_W];
  assign tick    = (qcnt == QW'(TICK_DIV - 1));
  assign last    = tick && (pcnt == len - 1'b1);
  assign slot_nx = slot_q + 1'b1;
  assign tx_st   = (st == S_WARM) || (st == S_RUP) || (st == S_MOD) || (st == S_TAIL) || (st == S_RDN);
  assign nsl_in  = (cfg_slots_i == '0) ? SLW'(1) :
                   (cfg_slots_i > SLW'(SLOTS_MAX)) ? SLW'(SLOTS_MAX) : cfg_slots_i;
  assign start   = strobe_i && !abort_i && (st == S_IDLE) && (!cfg_tx_i || batt_ok_i);
  assign kill    = abort_i || (tx_st && !batt_ok_i) ||
                   ((st == S_RXSTR) && (strobe_i || rx_end_i)) || ((st == S_RXDC) && rx_end_i);

  always_comb begin
    len   = PW'(1);
    st_nx = st;
    case (st)
      S_WARM:  begin len = PW'(WARM_Q); st_nx = S_RUP; end
      S_RUP:   begin len = PW'(RAMP_Q); st_nx = S_MOD; end
      S_MOD:   begin len = PW'(MOD_Q);  st_nx = (cur_sd != '0) ? S_TAIL : S_RDN; end
      S_TAIL:  begin len = PW'(cur_sd); st_nx = S_RDN; end
      S_RDN:   begin len = PW'(RAMP_Q); st_nx = (slot_nx < nsl_q) ? S_RUP : S_IDLE; end
      S_RXDC:  begin len = PW'(DCA_Q);  st_nx = S_RXSTR; end
      default: begin len = PW'(1);      st_nx = st; end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; qcnt <= '0; pcnt <= '0; slot_q <= '0; nsl_q <= '0; cfg_q <= '0;
    end else if (kill) begin
      st <= S_IDLE; slot_q <= '0;
    end else if (start) begin
      st     <= cfg_tx_i ? S_WARM : S_RXDC;
      qcnt   <= '0;
      pcnt   <= '0;
      slot_q <= '0;
      nsl_q  <= nsl_in;
      cfg_q  <= cfg_slot_i;
    end else if (st != S_IDLE) begin
      qcnt <= tick ? '0 : qcnt + 1'b1;
      if (last) begin
        pcnt <= '0;
        st   <= st_nx;
        if (st == S_RDN) slot_q <= (st_nx == S_RUP) ? slot_nx : '0;
      end else if (tick) begin
        pcnt <= pcnt + 1'b1;
      end
    end
  end

  assign busy_o     = (st != S_IDLE);
  assign synth_en_o = busy_o;
  assign ramp_up_o  = (st == S_RUP);
  assign ramp_dn_o  = (st == S_RDN);
  assign mod_en_o   = (st == S_MOD) || (st == S_TAIL);
  assign rx_en_o    = (st == S_RXDC) || (st == S_RXSTR);
  assign rx_data_o  = (st == S_RXSTR);
  assign slot_o     = tx_st ? slot_q : '0;
  assign mode_o     = tx_st & cur[0];
  assign power_o    = tx_st ? cur[PWR_W:1] : '0;

  p_tick_grid_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ramp_up_o) |-> (qcnt == '0));
  p_slot_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |-> (slot_o < SLW'(SLOTS_MAX)));
  p_cfg_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && $past(busy_o) && $stable(slot_o)) |-> ($stable(power_o) && $stable(mode_o)));
  p_rx_end_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_data_o && (strobe_i || rx_end_i)) |=> !busy_o);
  p_lowbatt_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!batt_ok_i && (ramp_up_o || ramp_dn_o || mod_en_o)) |=> !busy_o);
  p_refuse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_o && strobe_i && cfg_tx_i && !batt_ok_i) |=> !busy_o);
  p_abort_r10: assert property (@(posedge clk) disable iff (!rst_n)
    abort_i |=> !busy_o);
  p_excl_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ramp_up_o, ramp_dn_o, mod_en_o, rx_en_o}));
endmodule

// File: tb/test_burst_seq.sv
`timescale 1ns/1ps
module test_burst_seq;
  localparam int TD = 24, WQ = 8, RQ = 4, DQ = 6, MQ = 32, NS = 6;

  logic clk = 0, rst_n = 0;
  logic strobe_i = 0, rx_end_i = 0, abort_i = 0, batt_ok_i = 1, cfg_tx_i = 0;
  logic [2:0]  cfg_slots_i = '0;
  logic [53:0] cfg_slot_i = '0;
  logic synth_en_o, ramp_up_o, ramp_dn_o, mod_en_o, rx_en_o, rx_data_o, busy_o, mode_o;
  logic [2:0] slot_o;
  logic [4:0] power_o;

  int n_chk = 0, n_fail = 0, t = 0;
  int md[NS], pw[NS], sd[NS];
  bit done = 0;

  always #2 clk = ~clk;

  burst_seq i_burst_seq (.*);

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s at cycle %0d: actual %0d expected %0d", req, t, act, exp);
    end
  endtask

  task automatic adv(int k);
    while (t < k) begin @(negedge clk); t++; end
  endtask

  task automatic start_burst();
    @(negedge clk); strobe_i = 1;
    @(negedge clk); strobe_i = 0; t = 0;
  endtask

  function automatic logic [53:0] pack();
    logic [53:0] v = '0;
    for (int i = 0; i < NS; i++) v[i*9 +: 9] = {sd[i][2:0], pw[i][4:0], md[i][0]};
    return v;
  endfunction

  task automatic run_tx(int ncfg, int nexp, bit scramble);
    int tt, rup, mdt, rdn;
    cfg_tx_i = 1; cfg_slots_i = 3'(ncfg); cfg_slot_i = pack();
    start_burst();
    if (scramble) begin cfg_slot_i = ~cfg_slot_i; cfg_slots_i = 3'd1; end
    chk("R3 synth on", synth_en_o, 1);
    chk("R3 busy", busy_o, 1);
    tt = WQ * TD;
    for (int s = 0; s < nexp; s++) begin
      rup = tt; mdt = rup + RQ * TD; rdn = mdt + MQ * TD + sd[s] * TD;
      adv(rup - 1);
      if (s == 0) chk("R2 ramp-up not yet", ramp_up_o, 0);
      else chk("R4 previous ramp-down", ramp_dn_o, 1);
      adv(rup);
      chk("R2 ramp-up start", ramp_up_o, 1);
      chk(scramble ? "R6 slot index" : "R4 slot index", slot_o, s);
      chk(scramble ? "R6 power" : "R4 power", power_o, pw[s]);
      chk(scramble ? "R6 mode" : "R4 mode", mode_o, md[s]);
      adv(mdt - 1); chk("R2 ramp-up end", ramp_up_o, 1);
      adv(mdt); chk("R3 modulating", mod_en_o, 1); chk("R11 ramp off", ramp_up_o, 0);
      adv(rdn - 1); chk("R3 tail modulating", mod_en_o, 1);
      adv(rdn); chk("R3 mod off", mod_en_o, 0); chk("R3 ramp-down", ramp_dn_o, 1);
      tt = rdn + RQ * TD;
    end
    adv(tt - 1); chk(nexp == 1 ? "R5 busy before end" : "R3 busy before end", busy_o, 1);
    adv(tt); chk("R3 standby", busy_o, 0); chk("R3 synth off", synth_en_o, 0);
  endtask

  task automatic t_reset();
    chk("R1 busy", busy_o, 0); chk("R1 synth", synth_en_o, 0);
    chk("R1 mod", mod_en_o, 0); chk("R1 rx", rx_en_o, 0); chk("R1 power", power_o, 0);
  endtask

  task automatic t_single();
    md = '{1,0,0,0,0,0}; pw = '{17,0,0,0,0,0}; sd = '{2,0,0,0,0,0};
    run_tx(1, 1, 1);
  endtask

  task automatic t_multi();
    md = '{0,1,1,0,0,0}; pw = '{3,30,9,0,0,0}; sd = '{0,3,1,0,0,0};
    run_tx(3, 3, 1);
  endtask

  task automatic t_clamp();
    md = '{1,0,1,0,1,0}; pw = '{5,6,7,8,9,10}; sd = '{1,0,2,0,1,0};
    run_tx(0, 1, 0);
    run_tx(7, 6, 0);
  endtask

  task automatic t_rx();
    cfg_tx_i = 0; start_burst();
    chk("R7 rx on", rx_en_o, 1); chk("R7 synth", synth_en_o, 1); chk("R7 dc-adapt", rx_data_o, 0);
    adv(50); strobe_i = 1; adv(51); strobe_i = 0;
    chk("R8 strobe ignored", rx_en_o, 1);
    adv(DQ * TD - 1); chk("R7 still adapting", rx_data_o, 0);
    adv(DQ * TD); chk("R7 streaming", rx_data_o, 1);
    adv(300); strobe_i = 1; adv(301); strobe_i = 0;
    chk("R7 strobe end", busy_o, 0); chk("R7 rx off", rx_en_o, 0);
    start_burst();
    adv(200); rx_end_i = 1; adv(201); rx_end_i = 0;
    chk("R7 rx-end", busy_o, 0);
  endtask

  task automatic t_busy_strobe();
    md = '{0,0,0,0,0,0}; pw = '{4,0,0,0,0,0}; sd = '{0,0,0,0,0,0};
    cfg_tx_i = 1; cfg_slots_i = 1; cfg_slot_i = pack(); start_burst();
    adv(400); strobe_i = 1; adv(401); strobe_i = 0;
    chk("R8 tx strobe ignored", mod_en_o, 1);
    adv(1152); chk("R8 end unchanged", busy_o, 0);
  endtask

  task automatic t_lowbatt();
    cfg_tx_i = 1; cfg_slots_i = 2; start_burst();
    adv(500); batt_ok_i = 0; adv(501);
    chk("R9 tx cut", busy_o, 0); chk("R9 mod off", mod_en_o, 0);
    start_burst(); chk("R9 tx refused", busy_o, 0);
    adv(5); chk("R9 still refused", busy_o, 0);
    cfg_tx_i = 0; start_burst(); chk("R9 rx accepted", rx_en_o, 1);
    rx_end_i = 1; adv(1); rx_end_i = 0;
    batt_ok_i = 1;
  endtask

  task automatic t_abort();
    cfg_tx_i = 1; cfg_slots_i = 1; start_burst();
    adv(250); abort_i = 1; adv(251); abort_i = 0;
    chk("R10 abort", busy_o, 0); chk("R10 ramp off", ramp_up_o, 0);
    @(negedge clk); strobe_i = 1; abort_i = 1;
    @(negedge clk); strobe_i = 0; abort_i = 0;
    chk("R10 strobe with abort", busy_o, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    @(negedge clk);
    t_single();
    t_multi();
    t_clamp();
    t_rx();
    t_busy_strobe();
    t_lowbatt();
    t_abort();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule